// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical byte address into the chip select of one of eight DRAM rows. Software programs one 8-bit boundary value per row. Each value is the cumulative top of its row, counted in 8 MB steps. A row therefore begins where the last populated row below it ends, and row 0 begins at address zero. A row that does not raise the running top holds no memory and is never selected. This covers a value equal to the current top and a value below it. A zero value that follows a populated row stands for the top of a 2 GB space. This lets a full-size memory be described with 8-bit values.

Each decode gives a one-hot chip select, the binary row number and an out-of-range flag, one clock after the address is applied. A separate inspection port reports the base and the size of any chosen row in 4 KB pages. Software can use these to place a logged error address in its row.

Top module: `dram_row_decoder`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_value` is stored as the boundary of row `wr_row`. A decode registered on a later edge uses the new value. The decode registered on that same edge still uses the old value.
- R2: A row's candidate limit is its boundary value shifted left by 23 bits, i.e. value × 8 MB. Row 0's base is 0. The base of every other row is the running limit, which is the highest limit of the rows below it.
- R3: A row whose candidate limit is equal to or below the running limit is empty. It is never selected, its reported size is zero, and it leaves the running limit unchanged. A decreasing value never makes the decoder choose a wrong row.
- R4: A zero boundary seen while the running limit is nonzero means 2 GB (bit 31 set). A zero boundary seen while the running limit is still zero makes the row empty.
- R5: An address in [base, limit) of a non-empty row gives `cs_onehot` with only that row's bit set, and `row_idx` equal to that row's number. Bit i of `cs_onehot` belongs to row i. The result appears one cycle after the address.
- R6: An address at or above the final running limit gives `out_of_range` = 1, `cs_onehot` = 0 and `row_idx` = 0. When all rows are empty, this holds for every address.
- R7: `insp_base_pg` and `insp_size_pg` give the base of row `insp_row` and its size (limit − base), both in 4 KB pages (bytes shifted right by 12). They appear one cycle after the row is selected.
- R8: After reset, all boundaries are 0, `cs_onehot` = 0, `row_idx` = 0, `out_of_range` = 1, and both inspection outputs are 0.
- R9: In every cycle, exactly one signal of the set {the bits of `cs_onehot`, `out_of_range`} is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Boundary write strobe |
| wr_row | input | 3 | Row whose boundary is written |
| wr_value | input | 8 | Boundary value in 8 MB units |
| addr | input | 32 | Byte address to decode |
| insp_row | input | 3 | Row chosen for inspection |
| cs_onehot | output | 8 | Registered one-hot chip select |
| row_idx | output | 3 | Registered number of the selected row |
| out_of_range | output | 1 | Registered flag: address lies above all rows |
| insp_base_pg | output | 20 | Base of the inspected row, in 4 KB pages |
| insp_size_pg | output | 20 | Size of the inspected row, in 4 KB pages |

## Verification
The bench uses the default parameters: eight rows, 8-bit boundaries and a 23-bit unit shift. The address is therefore 32 bits wide, and the 2 GB value produced by a wrapped zero lies just inside it. With these values the bench can place addresses on both sides of the 2 GB top, including 0x7FFFFFFF and 0x80000000. It also reaches empty rows from repeated values and from decreasing values, and a zero in row 0 that must not wrap. The page outputs stay 20 bits wide, so a 1.875 GB row size can be compared exactly.

// File: rtl/drd_pkg.sv
package drd_pkg;
    // Default geometry shared by all decoder submodules.
    localparam int DRD_ROWS       = 8;
    localparam int DRD_BND_W      = 8;
    localparam int DRD_UNIT_SHIFT = 23;
    localparam int DRD_PAGE_SHIFT = 12;

    function automatic int drd_idx_w(input int rows);
        return (rows > 1) ? $clog2(rows) : 1;
    endfunction
endpackage

// File: rtl/drd_bound_regs.sv
module drd_bound_regs
    import drd_pkg::*;
#(
    parameter int ROWS  = DRD_ROWS,
    parameter int BND_W = DRD_BND_W,
    localparam int IDX_W = drd_idx_w(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_row,
    input  logic [BND_W-1:0]           wr_value,
    output logic [ROWS-1:0][BND_W-1:0] bnd
);
    typedef struct packed {
        logic [ROWS-1:0][BND_W-1:0] bnd;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (int'(wr_row) < ROWS)) begin
            regs_d.bnd[wr_row] = wr_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bnd = regs_q.bnd;

    // R1: a write lands in the addressed row on the following cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_row) < ROWS)) |=> bnd[$past(wr_row)] == $past(wr_value));
endmodule

// File: rtl/drd_row_map.sv
module drd_row_map
    import drd_pkg::*;
#(
    parameter int ROWS       = DRD_ROWS,
    parameter int BND_W      = DRD_BND_W,
    parameter int UNIT_SHIFT = DRD_UNIT_SHIFT,
    localparam int LIM_W     = BND_W + UNIT_SHIFT + 1
) (
    input  logic [ROWS-1:0][BND_W-1:0] bnd,
    output logic [ROWS-1:0][LIM_W-1:0] row_base,
    output logic [ROWS-1:0][LIM_W-1:0] row_lim,
    output logic [ROWS-1:0]            row_empty,
    output logic [LIM_W-1:0]           top_lim
);
    // A zero following populated rows stands for the first value past the field.
    localparam logic [LIM_W-1:0] WRAP_LIM = LIM_W'(1) << (BND_W + UNIT_SHIFT);

    always_comb begin
        logic [LIM_W-1:0] run_lim;
        logic [LIM_W-1:0] cand;
        run_lim = '0;
        cand    = '0;
        for (int i = 0; i < ROWS; i++) begin
            cand = LIM_W'(bnd[i]) << UNIT_SHIFT;
            if ((cand == '0) && (run_lim != '0)) begin
                cand = WRAP_LIM;
            end
            row_base[i] = run_lim;
            if (cand > run_lim) begin
                row_lim[i]   = cand;
                row_empty[i] = 1'b0;
                run_lim      = cand;
            end else begin
                row_lim[i]   = run_lim;
                row_empty[i] = 1'b1;
            end
        end
        top_lim = run_lim;
    end
endmodule

// File: rtl/drd_match.sv
module drd_match
    import drd_pkg::*;
#(
    parameter int ROWS  = DRD_ROWS,
    parameter int LIM_W = DRD_BND_W + DRD_UNIT_SHIFT + 1,
    localparam int IDX_W = drd_idx_w(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LIM_W-1:0]           addr,
    input  logic [ROWS-1:0][LIM_W-1:0] row_base,
    input  logic [ROWS-1:0][LIM_W-1:0] row_lim,
    input  logic [ROWS-1:0]            row_empty,
    input  logic [LIM_W-1:0]           top_lim,
    output logic [ROWS-1:0]            cs_onehot,
    output logic [IDX_W-1:0]           row_idx,
    output logic                       out_of_range
);
    typedef struct packed {
        logic [ROWS-1:0]  cs;
        logic [IDX_W-1:0] idx;
        logic             oor;
    } sel_t;

    sel_t sel_d, sel_q;
    logic [ROWS-1:0] hit;

    for (genvar g = 0; g < ROWS; g++) begin : g_hit
        assign hit[g] = !row_empty[g] && (addr >= row_base[g]) && (addr < row_lim[g]);

        // R3: an empty row is never driven as the chip select
        a_r3_empty_unselected: assert property (@(posedge clk) disable iff (!rst_n)
            row_empty[g] |=> !cs_onehot[g]);
    end

    // Lowest-numbered hit wins; scan downward so the last assignment is row 0.
    always_comb begin
        sel_d.cs  = '0;
        sel_d.idx = '0;
        sel_d.oor = 1'b1;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_d.cs  = ROWS'(1) << i;
                sel_d.idx = IDX_W'(i);
                sel_d.oor = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.cs  <= '0;
            sel_q.idx <= '0;
            sel_q.oor <= 1'b1;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign cs_onehot    = sel_q.cs;
    assign row_idx      = sel_q.idx;
    assign out_of_range = sel_q.oor;

    // R9: exactly one of the chip selects and the range flag is high
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cs_onehot, out_of_range}) == 1);

    // R5: the row number names the asserted chip select
    a_r5_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        !out_of_range |-> cs_onehot == (ROWS'(1) << row_idx));

    // R6: addresses at or above the running top are flagged next cycle
    a_r6_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= top_lim) |=> out_of_range);

    // R6: addresses below the running top always land in a row
    a_r6_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < top_lim) |=> !out_of_range);
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
    import drd_pkg::*;
#(
    parameter int ROWS       = DRD_ROWS,
    parameter int BND_W      = DRD_BND_W,
    parameter int UNIT_SHIFT = DRD_UNIT_SHIFT,
    parameter int PAGE_SHIFT = DRD_PAGE_SHIFT,
    localparam int IDX_W     = drd_idx_w(ROWS),
    localparam int LIM_W     = BND_W + UNIT_SHIFT + 1,
    localparam int PG_W      = LIM_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [BND_W-1:0] wr_value,
    input  logic [LIM_W-1:0] addr,
    input  logic [IDX_W-1:0] insp_row,
    output logic [ROWS-1:0]  cs_onehot,
    output logic [IDX_W-1:0] row_idx,
    output logic             out_of_range,
    output logic [PG_W-1:0]  insp_base_pg,
    output logic [PG_W-1:0]  insp_size_pg
);
    logic [ROWS-1:0][BND_W-1:0] bnd;
    logic [ROWS-1:0][LIM_W-1:0] row_base;
    logic [ROWS-1:0][LIM_W-1:0] row_lim;
    logic [ROWS-1:0]            row_empty;
    logic [LIM_W-1:0]           top_lim;

    drd_bound_regs #(
        .ROWS  (ROWS),
        .BND_W (BND_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_value (wr_value),
        .bnd      (bnd)
    );

    drd_row_map #(
        .ROWS       (ROWS),
        .BND_W      (BND_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_map (
        .bnd       (bnd),
        .row_base  (row_base),
        .row_lim   (row_lim),
        .row_empty (row_empty),
        .top_lim   (top_lim)
    );

    drd_match #(
        .ROWS  (ROWS),
        .LIM_W (LIM_W)
    ) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .row_base     (row_base),
        .row_lim      (row_lim),
        .row_empty    (row_empty),
        .top_lim      (top_lim),
        .cs_onehot    (cs_onehot),
        .row_idx      (row_idx),
        .out_of_range (out_of_range)
    );

    // Inspection stage: base and size of one row, in pages.
    typedef struct packed {
        logic [PG_W-1:0] base;
        logic [PG_W-1:0] size;
    } insp_t;

    insp_t insp_d, insp_q;

    always_comb begin
        insp_d = '0;
        if (int'(insp_row) < ROWS) begin
            insp_d.base = row_base[insp_row][LIM_W-1:PAGE_SHIFT];
            insp_d.size = PG_W'((row_lim[insp_row] - row_base[insp_row]) >> PAGE_SHIFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insp_q <= '0;
        end else begin
            insp_q <= insp_d;
        end
    end

    assign insp_base_pg = insp_q.base;
    assign insp_size_pg = insp_q.size;

    // R2: the running limit never falls from one row to the next
    for (genvar g = 1; g < ROWS; g++) begin : g_mono
        a_r2_limits_rise: assert property (@(posedge clk) disable iff (!rst_n)
            row_lim[g] >= row_lim[g-1]);
    end

    // R3: an inspected empty row reports zero size
    a_r3_empty_size: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(insp_row) < ROWS) && row_empty[insp_row]) |=> insp_size_pg == '0);
endmodule

// File: tb/dram_row_decoder_test.sv
module dram_row_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [7:0]  wr_value = '0;
    logic [31:0] addr = '0;
    logic [2:0]  insp_row = '0;
    logic [7:0]  cs_onehot;
    logic [2:0]  row_idx;
    logic        out_of_range;
    logic [19:0] insp_base_pg;
    logic [19:0] insp_size_pg;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    dram_row_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_row       (wr_row),
        .wr_value     (wr_value),
        .addr         (addr),
        .insp_row     (insp_row),
        .cs_onehot    (cs_onehot),
        .row_idx      (row_idx),
        .out_of_range (out_of_range),
        .insp_base_pg (insp_base_pg),
        .insp_size_pg (insp_size_pg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_bnd(input int row, input int val);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_row   = 3'(row);
        wr_value = 8'(val);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    // Apply an address, sample one cycle later (R5 latency), check R9 too.
    task automatic decode(input string tag, input logic [31:0] a, input bit exp_oor, input int exp_idx);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        cmp({tag, " oor"}, 64'(out_of_range), 64'(exp_oor));
        cmp({tag, " cs"}, 64'(cs_onehot), exp_oor ? 64'd0 : (64'd1 << exp_idx));
        cmp({tag, " idx"}, 64'(row_idx), exp_oor ? 64'd0 : 64'(exp_idx));
        cmp({tag, " R9 one-of"}, 64'($countones({cs_onehot, out_of_range})), 64'd1);
    endtask

    task automatic inspect(input string tag, input int row, input int exp_base, input int exp_size);
        @(negedge clk);
        insp_row = 3'(row);
        @(negedge clk);
        cmp({tag, " base_pg"}, 64'(insp_base_pg), 64'(exp_base));
        cmp({tag, " size_pg"}, 64'(insp_size_pg), 64'(exp_size));
    endtask

    task automatic t_reset();
        @(negedge clk);
        cmp("R8 reset cs", 64'(cs_onehot), 64'd0);
        cmp("R8 reset idx", 64'(row_idx), 64'd0);
        cmp("R8 reset oor", 64'(out_of_range), 64'd1);
        cmp("R8 reset base", 64'(insp_base_pg), 64'd0);
        cmp("R8 reset size", 64'(insp_size_pg), 64'd0);
        decode("R6 all empty addr 0", 32'h0, 1'b1, 0);
        decode("R6 all empty addr max", 32'hFFFF_FFFF, 1'b1, 0);
    endtask

    // Rows: 4,4,12,8,16,16,16,16 -> row0 [0,32M), row2 [32M,96M), row4 [96M,128M)
    task automatic t_map();
        write_bnd(0, 4);
        write_bnd(1, 4);
        write_bnd(2, 12);
        write_bnd(3, 8);
        write_bnd(4, 16);
        write_bnd(5, 16);
        write_bnd(6, 16);
        write_bnd(7, 16);
        decode("R5 R2 row0 low", 32'h0000_0000, 1'b0, 0);
        decode("R5 row0 top", 32'h01FF_FFFF, 1'b0, 0);
        decode("R3 equal skip to row2", 32'h0200_0000, 1'b0, 2);
        decode("R5 row2 top", 32'h05FF_FFFF, 1'b0, 2);
        decode("R3 decrease skip to row4", 32'h0600_0000, 1'b0, 4);
        decode("R5 row4 top", 32'h07FF_FFFF, 1'b0, 4);
        decode("R6 at top", 32'h0800_0000, 1'b1, 0);
    endtask

    task automatic t_inspect();
        inspect("R7 R2 row0", 0, 'h0000, 'h2000);
        inspect("R7 R3 row1 empty", 1, 'h2000, 0);
        inspect("R7 row2", 2, 'h2000, 'h4000);
        inspect("R7 R3 row3 decreasing", 3, 'h6000, 0);
        inspect("R7 row4", 4, 'h6000, 'h2000);
    endtask

    task automatic t_wrap();
        write_bnd(5, 0);
        decode("R4 wrap row5 low", 32'h0800_0000, 1'b0, 5);
        decode("R4 wrap row5 top", 32'h7FFF_FFFF, 1'b0, 5);
        decode("R4 R6 just past 2G", 32'h8000_0000, 1'b1, 0);
        decode("R6 max addr", 32'hFFFF_FFFF, 1'b1, 0);
        inspect("R4 R7 row5 size", 5, 'h8000, 'h78000);
        inspect("R3 row6 below wrapped limit", 6, 'h80000, 0);
    endtask

    task automatic t_zero_first();
        write_bnd(0, 0);
        decode("R4 leading zero no wrap", 32'h0000_0000, 1'b0, 1);
        inspect("R4 row0 empty", 0, 0, 0);
        inspect("R2 row1 base 0", 1, 0, 'h2000);
    endtask

    // R1: decode on the write edge still sees the old value, the next sees the new one.
    task automatic t_write_latency();
        @(negedge clk);
        addr     = 32'h0;
        wr_en    = 1'b1;
        wr_row   = 3'd0;
        wr_value = 8'd2;
        @(negedge clk);
        wr_en = 1'b0;
        cmp("R1 old value on write edge idx", 64'(row_idx), 64'd1);
        @(negedge clk);
        cmp("R1 new value next edge idx", 64'(row_idx), 64'd0);
        cmp("R1 new value next edge cs", 64'(cs_onehot), 64'd1);
        decode("R1 row1 now starts at 16M", 32'h0100_0000, 1'b0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_inspect();
        t_wrap();
        t_zero_first();
        t_write_latency();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule